// File: doc/BRIEF.md
# End-of-Write Status Responder

This block sits on the read path of a byte-wide nonvolatile memory. It decides what a host sees on the read data bus while an internal write cycle is in progress. The host can find out when the cycle ends in three ways, and all three share one byte. The first is a polled bit that reads inverted for the byte last written. The second is a bit that flips on each completed read. The third is a bit that reports whether the byte-load window has closed. Once the cycle is over, reads return the addressed array byte unchanged.

The block does not store the array and does not sequence writes. The write controller supplies the busy level, the load-window state, the address of the last byte loaded and that byte's polled bit. The array supplies the byte at the current read address. A read begins on the rising edge of the read strobe, and its result is registered on that edge. The read counts as completed when the strobe drops. A separate output reports the state of the load timer at all times.

Top module: `eow_status_responder`

## Requirements
- R1: While reset is asserted and after it is released, before any read, the read data is 0x00 and the timer flag is 0.
- R2: With no write cycle in progress, a read returns the array byte for the read address unchanged. The byte appears on the read data one clock after the strobe is first seen high and holds until the next read starts.
- R3: During a write cycle, a read of the last-written address returns the complement of the last byte's bit 7 on bit 7.
- R4: During a write cycle, a read of any other address returns the array's bit 7 on bit 7.
- R5: During a write cycle, bit 6 of the read data carries the toggle state. The first read captured after the cycle starts returns 0 on bit 6.
- R6: The toggle flips once for each completed read (strobe falling) that was captured during a write cycle. A strobe held high for several clocks counts once. A read captured before the cycle began does not advance the toggle.
- R7: The toggle returns to 0 whenever a new write cycle begins, even if it was 1 at the end of the previous cycle. This includes a read that starts on the same clock as the new cycle.
- R8: During a write cycle, bit 5 of the read data is 1 and bits 4 to 0 are 0.
- R9: The timer flag is registered. It is 0 while the load window is open, 1 while a write cycle runs with the window closed, and 0 when idle.
- R10: After a write cycle ends, the toggle stops and a read of the last-written address returns the full array byte, including its true bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrBusy | input | 1 | Internal write cycle in progress |
| loadRun | input | 1 | Byte-load window open (load timer running) |
| lastAddr | input | 15 | Address of the last byte loaded |
| lastPollBit | input | 1 | Bit 7 of the last byte loaded |
| rdStrobe | input | 1 | Read strobe; rising edge starts a read, falling edge completes it |
| rdAddr | input | 15 | Read address |
| arrayData | input | 8 | Array byte at the read address |
| rdData | output | 8 | Registered read data |
| timerFlag | output | 1 | Load timer expired / programming running |

## Verification
The hardest situation to reach is a read whose strobe rises on the very clock that a new write cycle starts, while the toggle was left at 1 by an odd number of reads in the previous cycle. The stimulus reaches it by running three status reads in one cycle and ending that cycle. It then raises the busy level and the read strobe on the same clock. A second awkward case is a read captured while idle that completes inside a new cycle. The bench holds the strobe across the busy rise so that this case also occurs.

// File: rtl/eow_pkg.sv
package eow_pkg;
  // Bit positions decoded by the host's polling routine
  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
  localparam int TIMER_BIT  = 5;

  typedef struct packed {
    logic captureRd;      // read strobe rose: register a response
    logic statusMode;     // response is a status byte
    logic advanceToggle;  // a status read has completed
    logic clearToggle;    // a new write cycle has begun
    logic timerDone;      // load window closed while programming
  } eowStrobes_t;
endpackage

// File: rtl/eow_ctrl.sv
module eow_ctrl
  import eow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrBusy,
  input  logic        loadRun,
  input  logic        rdStrobe,
  output eowStrobes_t strobes
);
  logic busyPrev;
  logic rdPrev;
  logic rdWasStatus;
  logic rdRise;
  logic rdFall;
  logic busyRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyPrev    <= 1'b0;
      rdPrev      <= 1'b0;
      rdWasStatus <= 1'b0;
    end else begin
      busyPrev <= wrBusy;
      rdPrev   <= rdStrobe;
      if (rdRise) rdWasStatus <= wrBusy;
    end
  end

  always_comb begin
    rdRise   = rdStrobe && !rdPrev;
    rdFall   = !rdStrobe && rdPrev;
    busyRise = wrBusy && !busyPrev;
    strobes.captureRd     = rdRise;
    strobes.statusMode    = wrBusy;
    strobes.advanceToggle = rdFall && rdWasStatus;
    strobes.clearToggle   = busyRise;
    strobes.timerDone     = wrBusy && !loadRun;
  end

  // R6
  held_read_no_recapture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && $past(rdStrobe)) |-> !strobes.captureRd);

  // R6
  advance_only_on_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advanceToggle |-> ($past(rdStrobe) && !rdStrobe));
endmodule

// File: rtl/eow_datapath.sv
module eow_datapath
  import eow_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  eowStrobes_t   strobes,
  input  logic [AW-1:0] rdAddr,
  input  logic [AW-1:0] lastAddr,
  input  logic          lastPollBit,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] rdData,
  output logic          timerFlag
);
  localparam int LOW_BITS = TIMER_BIT;

  logic          toggleQ;
  logic          toggleUse;
  logic          addrHit;
  logic          timerQ;
  logic [DW-1:0] rdDataQ;
  logic [DW-1:0] statusWord;

  always_comb begin
    addrHit   = (rdAddr == lastAddr);
    toggleUse = strobes.clearToggle ? 1'b0 : toggleQ;
    statusWord = '0;
    statusWord[POLL_BIT]   = addrHit ? ~lastPollBit : arrayData[POLL_BIT];
    statusWord[TOGGLE_BIT] = toggleUse;
    statusWord[TIMER_BIT]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleQ <= 1'b0;
      rdDataQ <= '0;
      timerQ  <= 1'b0;
    end else begin
      if (strobes.clearToggle)        toggleQ <= 1'b0;
      else if (strobes.advanceToggle) toggleQ <= ~toggleQ;
      if (strobes.captureRd)
        rdDataQ <= strobes.statusMode ? statusWord : arrayData;
      timerQ <= strobes.timerDone;
    end
  end

  assign rdData    = rdDataQ;
  assign timerFlag = timerQ;

  // R2
  idle_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.captureRd && !strobes.statusMode) |-> rdDataQ == $past(arrayData));

  // R3
  poll_invert_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.captureRd && strobes.statusMode && (rdAddr == lastAddr))
      |-> rdDataQ[POLL_BIT] != $past(lastPollBit));

  // R8
  status_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.captureRd && strobes.statusMode)
      |-> (rdDataQ[TIMER_BIT] && (rdDataQ[LOW_BITS-1:0] == '0)));

  // R7
  fresh_cycle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.clearToggle && strobes.captureRd) |-> !rdDataQ[TOGGLE_BIT]);

  // R6
  toggle_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toggleQ != $past(toggleQ)) |-> $past(strobes.advanceToggle || strobes.clearToggle));
endmodule

// File: rtl/eow_status_responder.sv
module eow_status_responder
  import eow_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrBusy,
  input  logic          loadRun,
  input  logic [AW-1:0] lastAddr,
  input  logic          lastPollBit,
  input  logic          rdStrobe,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] rdData,
  output logic          timerFlag
);
  eowStrobes_t strobes;

  eow_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrBusy   (wrBusy),
    .loadRun  (loadRun),
    .rdStrobe (rdStrobe),
    .strobes  (strobes)
  );

  eow_datapath #(.AW(AW), .DW(DW)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rdAddr      (rdAddr),
    .lastAddr    (lastAddr),
    .lastPollBit (lastPollBit),
    .arrayData   (arrayData),
    .rdData      (rdData),
    .timerFlag   (timerFlag)
  );
endmodule

// File: tb/eow_status_responder_test.sv
module eow_status_responder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrBusy = 1'b0;
  logic        loadRun = 1'b0;
  logic [14:0] lastAddr = '0;
  logic        lastPollBit = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [14:0] rdAddr = '0;
  logic [7:0]  arrayData;
  logic [7:0]  rdData;
  logic        timerFlag;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  // behavioural model state
  int   mTog = 0, mBusyPrev = 0, mRdPrev = 0, mWasStat = 0;
  logic [7:0] mData = 8'h00;
  logic mTimer = 1'b0;
  string mTag = "R1";

  function automatic logic [7:0] arrFn(input logic [14:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  assign arrayData = arrFn(rdAddr);

  always #(CLK_PERIOD/2) clk = ~clk;

  eow_status_responder uut (
    .clk(clk), .rstN(rstN), .wrBusy(wrBusy), .loadRun(loadRun),
    .lastAddr(lastAddr), .lastPollBit(lastPollBit), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .arrayData(arrayData), .rdData(rdData), .timerFlag(timerFlag)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mData = 8'h00; mTimer = 1'b0; mTog = 0; mBusyPrev = 0; mRdPrev = 0; mWasStat = 0;
      mTag = "R1";
    end else begin
      int busyRise, rise, fall, togUse;
      logic b7;
      busyRise = (wrBusy && mBusyPrev == 0) ? 1 : 0;
      rise = (rdStrobe && mRdPrev == 0) ? 1 : 0;
      fall = (!rdStrobe && mRdPrev == 1) ? 1 : 0;
      togUse = busyRise ? 0 : mTog;
      if (rise) begin
        if (wrBusy) begin
          b7 = (rdAddr == lastAddr) ? ~lastPollBit : arrayData[7];
          mData = {b7, togUse[0], 1'b1, 5'b00000};
          mTag = "R5";
        end else begin
          mData = arrayData;
          mTag = "R2";
        end
        mWasStat = wrBusy ? 1 : 0;
      end
      if (busyRise) mTog = 0;
      else if (fall && mWasStat == 1) mTog = 1 - mTog;
      mTimer = wrBusy && !loadRun;
      mBusyPrev = wrBusy ? 1 : 0;
      mRdPrev = rdStrobe ? 1 : 0;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(mTag, rdData, mData);
      chk("R9", {7'b0, timerFlag}, {7'b0, mTimer});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic readOp(input logic [14:0] a, input int hold, output logic [7:0] v);
    @(negedge clk);
    rdAddr = a;
    rdStrobe = 1'b1;
    @(negedge clk);
    v = rdData;
    for (int i = 1; i < hold; i++) @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1", rdData, 8'h00);
    chk("R1", {7'b0, timerFlag}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", rdData, 8'h00);

    // R2: idle read passes array data
    readOp(15'h0123, 1, v);
    chk("R2", v, 8'h79);
    @(negedge clk);
    chk("R2", rdData, 8'h79);

    // R9: load window open
    loadRun = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9", {7'b0, timerFlag}, 8'h00);

    // write cycle begins, last byte at 0x0040 with bit 7 = 1
    lastAddr = 15'h0040;
    lastPollBit = 1'b1;
    loadRun = 1'b0;
    wrBusy = 1'b1;
    @(negedge clk);
    chk("R9", {7'b0, timerFlag}, 8'h01);

    readOp(15'h0040, 1, v);
    chk("R3", v, 8'h20);
    chk("R5", v, 8'h20);
    chk("R8", v & 8'h3F, 8'h20);

    readOp(15'h0040, 3, v);
    chk("R6", v, 8'h60);

    readOp(15'h01A5, 1, v);
    chk("R4", v, 8'hA0);
    chk("R6", v & 8'h40, 8'h00);

    // cycle ends with toggle left at 1
    @(negedge clk);
    wrBusy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9", {7'b0, timerFlag}, 8'h00);
    readOp(15'h0040, 1, v);
    chk("R10", v, 8'h1A);
    readOp(15'h0040, 2, v);
    chk("R10", v, 8'h1A);

    // R7: new cycle and read start on the same clock
    @(negedge clk);
    lastPollBit = 1'b0;
    wrBusy = 1'b1;
    rdAddr = 15'h0040;
    rdStrobe = 1'b1;
    @(negedge clk);
    chk("R7", rdData, 8'hA0);
    rdStrobe = 1'b0;
    @(negedge clk);

    // R6: read captured while idle, completed inside a new cycle
    wrBusy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rdAddr = 15'h0002;
    rdStrobe = 1'b1;
    @(negedge clk);
    chk("R2", rdData, 8'h58);
    wrBusy = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
    readOp(15'h0040, 1, v);
    chk("R6", v, 8'hA0);
    readOp(15'h0040, 1, v);
    chk("R5", v, 8'hE0);

    @(negedge clk);
    wrBusy = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule